// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block sits behind the input pins of an I2C target and watches the SCL and SDA lines. It oversamples them on a fast system clock through a two-stage synchroniser. It finds START, repeated START and STOP conditions, and it shifts in the first byte that follows each START, most significant bit first, on SCL rising edges.

If the first byte after a START carries the high-speed master code prefix, the block enters high-speed mode. It raises a sticky mode flag and switches the glitch-filter setting it drives to the narrow value. It also emits a one-cycle master-code pulse in place of an address pulse, and the downstream target engine uses that pulse to leave SDA released on the ninth clock. For any other first byte it emits an address-received pulse and presents the byte. The mode flag survives repeated STARTs and falls only at the next STOP.

The system clock is assumed to run at least eight times faster than SCL.

Top module: `i2cHsDetect`

## Requirements
- R1: After reset, hsActive is 0, filterSel equals the standard/fast setting (FILT_STD), and neither addrValid nor mcPulse is asserted.
- R2: When the first byte after a START in standard/fast mode has bits [7:3] equal to 5'b00001, the block raises hsActive and gives exactly one mcPulse, with no addrValid.
- R3: Bits [2:0] of the master code byte, including bit 0, are not decoded. Every value from 0x08 to 0x0F enters high-speed mode in the same way.
- R4: Any other first byte after a START gives exactly one addrValid pulse, with rxByte equal to the received byte. hsActive is left unchanged.
- R5: filterSel equals FILT_HS while hsActive is 1, and FILT_STD while it is 0.
- R6: A repeated START while in high-speed mode keeps hsActive at 1. The byte after it is reported through addrValid, even if it matches the master code prefix.
- R7: A STOP condition (SDA rising while SCL is high) clears hsActive and returns filterSel to FILT_STD.
- R8: A START or STOP in the middle of a byte aborts that byte and clears the bit count. A STOP abort gives no pulse. After a START abort, the next full byte is decoded as a first byte.
- R9: Only the first byte after each START is decoded. Later bytes in the same transfer give no pulse and do not change hsActive.
- R10: A bit is sampled as the SDA level at an SCL rising edge, and the first bit received becomes rxByte[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| hsActive | output | 1 | High-speed mode flag; the target must not acknowledge the byte flagged by mcPulse |
| filterSel | output | FILT_W | Glitch-filter setting for the input pads |
| rxByte | output | 8 | Most recent byte shifted in |
| addrValid | output | 1 | One-cycle pulse: a normal address byte was received |
| mcPulse | output | 1 | One-cycle pulse: the high-speed master code was received |

## Verification
The bench sends the master code with several different low bits. A decoder that reads bit 0 as a direction bit would then miss some of these codes or report them as addresses. It sends a master code after a repeated START and after a completed first byte. A design that decodes every byte, or that lets a repeated START reset the mode, would drop hsActive or pulse mcPulse at the wrong time. It also cuts bytes short with START and with STOP. A bit counter that is not cleared would then misalign the next byte, and the bench would see a wrong rxByte, or a pulse where none should come.

// File: rtl/i2cHsPkg.sv
package i2cHsPkg;
  typedef struct packed {
    logic clearCnt;
    logic shiftEn;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_REST  = 2'd2
  } ctlState_e;
endpackage

// File: rtl/i2cHsDatapath.sv
module i2cHsDatapath
  import i2cHsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output logic              startCond,
  output logic              stopCond,
  output logic              byteFull,
  output logic [BYTE_W-1:0] shiftReg
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclNow, sdaNow, sclRise;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclPipe[SYNC_STAGES-1];
  assign sdaNow    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclNow && !sclPrev;
  assign startCond = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopCond  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign byteFull  = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctl.clearCnt) begin
      bitCnt <= '0;
    end else if (sclRise && ctl.shiftEn && !byteFull) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W)); // R8
  AST_COND_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (startCond || stopCond) |=> (bitCnt == '0)); // R8
  AST_NO_START_AND_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !(startCond && stopCond)); // R7
endmodule

// File: rtl/i2cHsControl.sv
module i2cHsControl
  import i2cHsPkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] MC_PREFIX = 5'b00001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCond,
  input  logic              stopCond,
  input  logic              byteFull,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl,
  output logic              hsActive,
  output logic              addrValid,
  output logic              mcPulse
);
  ctlState_e state;
  logic      isPrefix;

  assign isPrefix     = (rxByte[BYTE_W-1 -: PREFIX_W] == MC_PREFIX);
  assign ctl.clearCnt = startCond || stopCond;
  assign ctl.shiftEn  = (state == ST_FIRST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hsActive  <= 1'b0;
      addrValid <= 1'b0;
      mcPulse   <= 1'b0;
    end else begin
      addrValid <= 1'b0;
      mcPulse   <= 1'b0;
      if (stopCond) begin
        state    <= ST_IDLE;
        hsActive <= 1'b0;
      end else if (startCond) begin
        state <= ST_FIRST;
      end else if (state == ST_FIRST && byteFull) begin
        state <= ST_REST;
        if (!hsActive && isPrefix) begin
          hsActive <= 1'b1;
          mcPulse  <= 1'b1;
        end else begin
          addrValid <= 1'b1;
        end
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(mcPulse && addrValid)); // R2
  AST_HS_ENTRY_VIA_MC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsActive) |-> mcPulse); // R2
  AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> !hsActive); // R7
  AST_RESTART_KEEPS_HS: assert property (@(posedge clk) disable iff (!rstN)
    (hsActive && startCond) |=> hsActive); // R6
  AST_HS_FALL_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsActive) |-> $past(stopCond)); // R7
endmodule

// File: rtl/i2cHsDetect.sv
module i2cHsDetect
  import i2cHsPkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               FILT_W      = 4,
  parameter logic [FILT_W-1:0] FILT_STD   = 4'd7,
  parameter logic [FILT_W-1:0] FILT_HS    = 4'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              hsActive,
  output logic [FILT_W-1:0] filterSel,
  output logic [7:0]        rxByte,
  output logic              addrValid,
  output logic              mcPulse
);
  localparam int BYTE_W = 8;

  dpCtl_t ctl;
  logic   startCond, stopCond, byteFull;

  i2cHsDatapath #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .startCond(startCond), .stopCond(stopCond), .byteFull(byteFull),
    .shiftReg(rxByte)
  );

  i2cHsControl #(.BYTE_W(BYTE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .startCond(startCond), .stopCond(stopCond),
    .byteFull(byteFull), .rxByte(rxByte), .ctl(ctl),
    .hsActive(hsActive), .addrValid(addrValid), .mcPulse(mcPulse)
  );

  assign filterSel = hsActive ? FILT_HS : FILT_STD;

  AST_FILT_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsActive) |-> (filterSel == FILT_STD)); // R5
endmodule

// File: tb/i2cHsDetect_tb.sv
module i2cHsDetect_tb;
  localparam int H = 8;
  localparam logic [3:0] FSTD = 4'd7;
  localparam logic [3:0] FHS  = 4'd1;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sda = 1'b1;
  logic hsActive, addrValid, mcPulse;
  logic [3:0] filterSel;
  logic [7:0] rxByte;
  int nChecks = 0, nFails = 0, addrCnt = 0, mcCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2cHsDetect u_dut (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda),
    .hsActive(hsActive), .filterSel(filterSel), .rxByte(rxByte),
    .addrValid(addrValid), .mcPulse(mcPulse));

  always @(posedge clk) begin
    if (addrValid) addrCnt <= addrCnt + 1;
    if (mcPulse)   mcCnt   <= mcCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendStart();
    sda = 1'b1; waitClk(H); scl = 1'b1; waitClk(H);
    sda = 1'b0; waitClk(H); scl = 1'b0; waitClk(H);
  endtask

  task automatic sendStop();
    sda = 1'b0; waitClk(H); scl = 1'b1; waitClk(H);
    sda = 1'b1; waitClk(H);
  endtask

  task automatic sendBit(input logic b);
    sda = b; waitClk(H); scl = 1'b1; waitClk(H); scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sendBit(1'b1);
    waitClk(H);
  endtask

  task automatic expectFirst(input logic [7:0] v, input bit mc, input bit hsExp, input string req);
    int a0 = addrCnt, m0 = mcCnt;
    sendByte(v);
    check(mcCnt - m0 == (mc ? 1 : 0), {req, " mcPulse count"}, mcCnt - m0, mc ? 1 : 0);
    check(addrCnt - a0 == (mc ? 0 : 1), {req, " addrValid count"}, addrCnt - a0, mc ? 0 : 1);
    check(hsActive == hsExp, {req, " hsActive"}, hsActive, hsExp);
    if (!mc) check(rxByte == v, {req, " rxByte"}, rxByte, v);
  endtask

  task automatic testReset();
    check(hsActive == 1'b0, "R1 hsActive", hsActive, 0);
    check(filterSel == FSTD, "R1 filterSel", filterSel, FSTD);
    check(addrCnt == 0 && mcCnt == 0, "R1 pulses", addrCnt + mcCnt, 0);
  endtask

  task automatic testAddress();
    sendStart(); expectFirst(8'hA4, 0, 0, "R4 addr A4");
    sendStop();
    sendStart(); expectFirst(8'h53, 0, 0, "R10 addr 53 msb first");
    sendStop();
    sendStart(); expectFirst(8'h10, 0, 0, "R4 near-prefix 10");
    sendStop();
  endtask

  task automatic testMasterCode();
    sendStart(); expectFirst(8'h08, 1, 1, "R2 code 08");
    check(filterSel == FHS, "R5 filter hs", filterSel, FHS);
    sendStop();
    check(hsActive == 1'b0, "R7 stop clears", hsActive, 0);
    check(filterSel == FSTD, "R7 filter back", filterSel, FSTD);
  endtask

  task automatic testDontCare();
    logic [7:0] codes [3] = '{8'h09, 8'h0F, 8'h0D};
    foreach (codes[k]) begin
      sendStart(); expectFirst(codes[k], 1, 1, "R3 low bits ignored");
      sendStop();
      check(hsActive == 1'b0, "R7 stop after code", hsActive, 0);
    end
  endtask

  task automatic testRepeatedStart();
    sendStart(); expectFirst(8'h0A, 1, 1, "R2 code 0A");
    sendStart(); expectFirst(8'hB7, 0, 1, "R6 addr after restart");
    sendStart(); expectFirst(8'h09, 0, 1, "R6 prefix as addr in hs");
    check(filterSel == FHS, "R5 filter kept", filterSel, FHS);
    sendStop();
    check(hsActive == 1'b0, "R7 stop ends hs", hsActive, 0);
  endtask

  task automatic testSecondByte();
    sendStart(); expectFirst(8'hA0, 0, 0, "R4 first A0");
    begin
      int a0 = addrCnt, m0 = mcCnt;
      sendByte(8'h08);
      check(mcCnt == m0 && addrCnt == a0, "R9 second byte no pulse", (mcCnt - m0) + (addrCnt - a0), 0);
      check(hsActive == 1'b0, "R9 second byte no hs", hsActive, 0);
    end
    sendStop();
  endtask

  task automatic testAbort();
    int a0, m0;
    sendStart();
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
    sendStart(); expectFirst(8'hA6, 0, 0, "R8 start abort realign");
    sendStop();
    sendStart();
    a0 = addrCnt; m0 = mcCnt;
    sendBit(0); sendBit(0); sendBit(0); sendBit(0); sendBit(1);
    sendStop(); waitClk(4 * H);
    check(addrCnt == a0 && mcCnt == m0, "R8 stop abort no pulse", (addrCnt - a0) + (mcCnt - m0), 0);
    check(hsActive == 1'b0, "R8 stop abort hs", hsActive, 0);
    sendStart(); expectFirst(8'h0C, 1, 1, "R8 fresh after abort");
    sendBit(1); sendBit(1); sendBit(0);
    sendStop();
    check(hsActive == 1'b0, "R7 stop mid-byte in hs", hsActive, 0);
  endtask

  initial begin
    waitClk(5); rstN = 1'b1; waitClk(5);
    testReset();
    testAddress();
    testMasterCode();
    testDontCare();
    testRepeatedStart();
    testSecondByte();
    testAbort();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule